// File: doc/BRIEF.md
# DDR Refresh Credit Scheduler

This block sits on the controller side of a DDR SDRAM rank. It decides when auto-refresh commands go out, and it runs the clock-enable handshake for power-down and self-refresh. An interval timer adds one unit of refresh debt every average refresh period. While the memory is busy, the scheduler may let debt build up to a ceiling of eight. At the ceiling the request becomes urgent and ignores the busy hint. A command arbiter takes each request through a request/grant pair, and it is assumed to have precharged every bank before it grants.

After each granted refresh, the block reports through two permission outputs when other commands may be issued again. The same outputs cover the exits from power-down and self-refresh. The self-refresh exit has two waits: a short one for commands other than reads and a long one for reads. All waits are parameters in picoseconds or clocks and are turned into clock counts from the clock period.

Top module: `ddr_refresh_credit_sched`

## Requirements
- R1: Outside self-refresh, `debt` rises by one on every REFI_CYC-th clock edge. The first rise comes REFI_CYC edges after reset is released, or after self-refresh exit.
- R2: With `debt` from 1 to 7, `ref_req` is high only when `mem_busy` was low at the previous clock edge. A `ref_gnt` seen while `ref_req` is high lowers `debt` by one at that edge.
- R3: When `debt` equals 8, `ref_urgent` is 1 and `ref_req` is raised whatever `mem_busy` is. Lockouts and a low clock enable still hold it back.
- R4: `debt` never exceeds 8. An interval elapsing with `debt` at 8 and no grant leaves it at 8 and sets `debt_err`, which stays set until reset.
- R5: A grant on the same edge as an interval elapse leaves `debt` unchanged. A `ref_gnt` while `ref_req` is low has no effect on `debt` or on the lockouts.
- R6: After an accepted grant, `act_ok`, `rd_ok` and `ref_req` are low for RFC_CYC cycles (10 with the bench parameters).
- R7: Self-refresh is entered on the edge after `sr_req` is seen high with no lockout active and no grant on that edge. `cke` goes low, `debt` is cleared, and no debt accrues while inside. `sr_req` takes priority over `pd_req`.
- R8: Self-refresh is left on the edge that sees `sr_req` low. `act_ok` stays low for XSNR_CYC cycles, and `rd_ok` stays low for XSRD_CK cycles.
- R9: Power-down is entered when `pd_req` is high, `debt` is below 8, no lockout is active and no grant is taken. Debt keeps accruing. The block leaves power-down when `pd_req` drops or when `debt` reaches 8.
- R10: After power-down exit, `act_ok`, `rd_ok` and `ref_req` stay low for PDEX_CYC cycles.
- R11: Reset gives `debt` = 0, `debt_err` = 0, `cke` = 1, `act_ok` = 1, `rd_ok` = 1, `ref_req` = 0 and `ref_urgent` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_busy | input | 1 | Hint that traffic is pending; defers non-urgent refreshes |
| ref_gnt | input | 1 | Arbiter grant; the refresh command issues on this edge |
| sr_req | input | 1 | Level request to stay in self-refresh |
| pd_req | input | 1 | Level request to stay in power-down |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_urgent | output | 1 | Debt at the ceiling of 8 |
| cke | output | 1 | Clock enable to the rank |
| act_ok | output | 1 | Activate, refresh and other non-read commands allowed |
| rd_ok | output | 1 | Read commands allowed |
| debt | output | $clog2(MAX_DEBT+1) | Outstanding refresh count |
| debt_err | output | 1 | Sticky flag: an interval elapsed at full debt |

## Verification
Every result shows up after a known number of edges. Debt moves on the edge that ends an interval or takes a grant, and `mem_busy` reaches `ref_req` one edge later because it is registered first. A lockout loaded at an edge releases exactly its count of edges afterwards, and state changes show on `cke` at the edge that decides them. The bench tracks the edge count since reset and waits a set number of edges for each vector. It then samples on the falling clock edge, so every expected value sits at a point where the count of registers is known.

// File: rtl/ddr_rfsh_pkg.sv
package ddr_rfsh_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_PD  = 2'd1,
    ST_SR  = 2'd2
  } pwr_state_e;

  // ceiling division of a time in ps by the clock period in ps
  function automatic int ps2cyc(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int REFI_CYC = 975
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);
  localparam int CW = (REFI_CYC < 2) ? 1 : $clog2(REFI_CYC);
  localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick = !hold && (cnt_q == LAST);

  // interval restarts from zero after every elapse
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));
  // no accrual while frozen
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt_q == '0));
endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr #(
  parameter int MAX_DEBT = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          inc,
  input  logic          dec,
  output logic [DW-1:0] debt,
  output logic          err
);
  localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_q <= '0;
      err_q  <= 1'b0;
    end else if (clear) begin
      debt_q <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10: begin
          if (debt_q == CAP) err_q  <= 1'b1;
          else               debt_q <= debt_q + 1'b1;
        end
        2'b01: if (debt_q != '0) debt_q <= debt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign debt = debt_q;
  assign err  = err_q;

  p_cap_r4: assert property (@(posedge clk) disable iff (rst)
    debt_q <= CAP);
  p_sat_err_r4: assert property (@(posedge clk) disable iff (rst)
    (debt_q == CAP && inc && !dec && !clear) |=> err_q && debt_q == CAP);
  p_both_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (inc && dec && !clear) |=> $stable(debt_q));
endmodule

// File: rtl/cmd_lockout_timer.sv
module cmd_lockout_timer #(
  parameter int CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= CW'(CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  p_countdown_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == CW'(CYC)));
endmodule

// File: rtl/ddr_refresh_credit_sched.sv
module ddr_refresh_credit_sched
  import ddr_rfsh_pkg::*;
#(
  parameter int CLK_PS   = 8000,
  parameter int REFI_PS  = 7_800_000,
  parameter int RFC_PS   = 75_000,
  parameter int XSNR_PS  = 75_000,
  parameter int XSRD_CK  = 200,
  parameter int PDEX_PS  = 6_000,
  parameter int MAX_DEBT = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_busy,
  input  logic          ref_gnt,
  input  logic          sr_req,
  input  logic          pd_req,
  output logic          ref_req,
  output logic          ref_urgent,
  output logic          cke,
  output logic          act_ok,
  output logic          rd_ok,
  output logic [DW-1:0] debt,
  output logic          debt_err
);
  localparam int REFI_CYC = ps2cyc(REFI_PS, CLK_PS);
  localparam int RFC_CYC  = ps2cyc(RFC_PS, CLK_PS);
  localparam int XSNR_CYC = ps2cyc(XSNR_PS, CLK_PS);
  localparam int PDEX_CYC = ps2cyc(PDEX_PS, CLK_PS);
  localparam int NLOCK    = 4;
  localparam int L_RFC = 0, L_XSNR = 1, L_XSRD = 2, L_PDEX = 3;
  localparam int LOCK_CYC [NLOCK] = '{RFC_CYC, XSNR_CYC, XSRD_CK, PDEX_CYC};
  localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

  pwr_state_e       state_q, state_d;
  logic             busy_q;
  logic             tick;
  logic [NLOCK-1:0] lock_load, lock_busy;
  logic             nr_lock, in_run, urgent, ref_fire;
  logic             sr_enter, sr_exit, pd_enter, pd_exit;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= mem_busy;
  end

  rfsh_interval_timer #(.REFI_CYC(REFI_CYC)) i_ival (
    .clk  (clk),
    .rst  (rst),
    .hold (state_q == ST_SR),
    .tick (tick)
  );

  rfsh_debt_ctr #(.MAX_DEBT(MAX_DEBT)) i_debt (
    .clk   (clk),
    .rst   (rst),
    .clear (sr_enter),
    .inc   (tick),
    .dec   (ref_fire),
    .debt  (debt),
    .err   (debt_err)
  );

  for (genvar g = 0; g < NLOCK; g++) begin : g_lock
    cmd_lockout_timer #(.CYC(LOCK_CYC[g])) i_lock (
      .clk  (clk),
      .rst  (rst),
      .load (lock_load[g]),
      .busy (lock_busy[g])
    );
  end

  assign nr_lock  = lock_busy[L_RFC] | lock_busy[L_XSNR] | lock_busy[L_PDEX];
  assign in_run   = (state_q == ST_RUN);
  assign urgent   = (debt == CAP);
  assign ref_req  = in_run && !nr_lock && (urgent || (debt != '0 && !busy_q));
  assign ref_fire = ref_req && ref_gnt;

  // power state transitions
  always_comb begin
    state_d  = state_q;
    sr_enter = 1'b0;
    sr_exit  = 1'b0;
    pd_enter = 1'b0;
    pd_exit  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (sr_req && !nr_lock && !ref_fire) begin
          state_d  = ST_SR;
          sr_enter = 1'b1;
        end else if (pd_req && !urgent && !nr_lock && !ref_fire) begin
          state_d  = ST_PD;
          pd_enter = 1'b1;
        end
      end
      ST_PD: begin
        if (!pd_req || urgent || sr_req) begin
          state_d = ST_RUN;
          pd_exit = 1'b1;
        end
      end
      ST_SR: begin
        if (!sr_req) begin
          state_d = ST_RUN;
          sr_exit = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign lock_load[L_RFC]  = ref_fire;
  assign lock_load[L_XSNR] = sr_exit;
  assign lock_load[L_XSRD] = sr_exit;
  assign lock_load[L_PDEX] = pd_exit;

  assign cke        = in_run;
  assign ref_urgent = urgent;
  assign act_ok     = in_run && !nr_lock;
  assign rd_ok      = act_ok && !lock_busy[L_XSRD];

  p_grant_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_gnt && !tick) |=> (debt == $past(debt) - DW'(1)));
  p_urgent_req_r3: assert property (@(posedge clk) disable iff (rst)
    (urgent && act_ok) |-> ref_req);
  p_rfc_block_r6: assert property (@(posedge clk) disable iff (rst)
    ref_fire |=> (!act_ok && !ref_req));
  p_cke_low_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (!ref_req && !act_ok && !rd_ok));
  p_sr_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SR && $past(state_q == ST_SR)) |-> $stable(debt));
  p_srx_block_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SR && !sr_req) |=> (cke && !act_ok && !rd_ok));
  p_rd_needs_act_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ok |-> act_ok);
  p_pd_forced_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PD && urgent) |=> cke);
endmodule

// File: tb/test_ddr_refresh_credit_sched.sv
module test_ddr_refresh_credit_sched;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_busy = 1'b0, ref_gnt = 1'b0, sr_req = 1'b0, pd_req = 1'b0;
  logic ref_req, ref_urgent, cke, act_ok, rd_ok, debt_err;
  logic [DW-1:0] debt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // interval 20 cycles, RFC 10, XSNR 10, XSRD 30, PDEX 1
  ddr_refresh_credit_sched #(
    .CLK_PS(8000), .REFI_PS(160_000), .RFC_PS(75_000),
    .XSNR_PS(75_000), .XSRD_CK(30), .PDEX_PS(6_000), .MAX_DEBT(8)
  ) i_ddr_refresh_credit_sched (
    .clk(clk), .rst(rst), .mem_busy(mem_busy), .ref_gnt(ref_gnt),
    .sr_req(sr_req), .pd_req(pd_req), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .cke(cke), .act_ok(act_ok), .rd_ok(rd_ok),
    .debt(debt), .debt_err(debt_err)
  );

  typedef struct packed {
    logic       busy, gnt, sr, pd;
    logic [9:0] cyc;
    logic [3:0] debt;
    logic       req, urg, act, rd, cke, err;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0, 20, 1, 0,0,1,1,1,0},  // R1 first interval; R2 busy defers
    '{0,0,0,0,  1, 1, 1,0,1,1,1,0},  // R2 busy released
    '{1,0,0,0,139, 8, 1,1,1,1,1,0},  // R3 urgent despite busy
    '{1,0,0,0, 20, 8, 1,1,1,1,1,1},  // R4 saturate + err
    '{1,1,0,0,  1, 7, 0,0,0,0,1,1},  // R2 grant; R6 lockout
    '{0,0,0,0,  8, 7, 0,0,0,0,1,1},  // R6 still locked
    '{0,0,0,0,  2, 7, 1,0,1,1,1,1},  // R6 released
    '{0,1,0,0,  1, 6, 0,0,0,0,1,1},  // R2 grant
    '{0,1,0,0,  9, 7, 0,0,0,0,1,1},  // R5 grant without req ignored
    '{0,0,0,0,  1, 7, 1,0,1,1,1,1},  // R6 released
    '{0,0,1,0,  1, 0, 0,0,0,0,0,1},  // R7 SR entry clears debt
    '{0,0,1,0,100, 0, 0,0,0,0,0,1},  // R7 no accrual
    '{0,0,0,0,  1, 0, 0,0,0,0,1,1},  // R8 exit lockouts
    '{0,0,0,0, 10, 0, 0,0,1,0,1,1},  // R8 non-read free, read blocked
    '{0,0,0,0, 20, 1, 1,0,1,1,1,1},  // R8 read free; R1 restart
    '{0,0,0,1,  1, 1, 0,0,0,0,0,1},  // R9 PD entry
    '{0,0,0,1,  9, 2, 0,0,0,0,0,1},  // R9 accrual in PD
    '{0,0,0,1,121, 8, 0,1,0,0,1,1},  // R9 forced exit; R10 lockout
    '{0,0,0,1,  1, 8, 1,1,1,1,1,1},  // R10 released; no re-entry
    '{0,1,0,1,  1, 7, 0,0,0,0,1,1},  // R9 grant blocks entry
    '{0,0,0,1, 10, 7, 1,0,1,1,1,1},  // R9 RFC lockout blocks entry
    '{0,0,0,1,  1, 7, 0,0,0,0,0,1},  // R9 PD entry
    '{0,0,0,0,  1, 7, 0,0,0,0,1,1},  // R10 exit lockout
    '{0,0,0,0,  1, 7, 1,0,1,1,1,1},  // R10 released
    '{0,0,0,0,  3, 7, 1,0,1,1,1,1},  // R2 steady
    '{0,1,0,0,  1, 7, 0,0,0,0,1,1},  // R5 grant with tick
    '{0,0,0,0, 10, 7, 1,0,1,1,1,1}   // R6 released
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input vec_t v);
    chk(tag, "debt", int'(debt), int'(v.debt));
    chk(tag, "ref_req", int'(ref_req), int'(v.req));
    chk(tag, "ref_urgent", int'(ref_urgent), int'(v.urg));
    chk(tag, "act_ok", int'(act_ok), int'(v.act));
    chk(tag, "rd_ok", int'(rd_ok), int'(v.rd));
    chk(tag, "cke", int'(cke), int'(v.cke));
    chk(tag, "debt_err", int'(debt_err), int'(v.err));
  endtask

  initial begin : watchdog
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    vec_t rst_v;
    rst_v = '{0,0,0,0, 0, 0, 0,0,1,1,1,0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_all("R11", rst_v);  // reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      mem_busy = VEC[i].busy;
      ref_gnt  = VEC[i].gnt;
      sr_req   = VEC[i].sr;
      pd_req   = VEC[i].pd;
      repeat (int'(VEC[i].cyc)) @(posedge clk);
      @(negedge clk);
      chk_all($sformatf("vec%0d", i), VEC[i]);
    end

    // R11: reset clears the sticky error and debt
    ref_gnt = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_all("R11", rst_v);

    // R7: self-refresh request wins over power-down request
    sr_req = 1'b1;
    pd_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7", "cke", int'(cke), 0);
    pd_req = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R7", "cke held", int'(cke), 0);
    sr_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8", "cke", int'(cke), 1);
    chk("R8", "act_ok", int'(act_ok), 0);
    chk("R8", "rd_ok", int'(rd_ok), 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R8", "act_ok after XSNR", int'(act_ok), 1);
    chk("R8", "rd_ok before XSRD", int'(rd_ok), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule